// File: doc/BRIEF.md
# Masked SIMD Lane Writeback Unit

This block sits between the operand read stage and the per-lane single-precision adders of a packed-add datapath that is up to sixteen 32-bit lanes (512 bits) wide. It routes the second operand to the adders. Depending on the request, that operand is either the matching element of the second source or element 0 of it, copied to every lane. The block also tells the adders which rounding mode to use.

When the adders return their per-lane sums, the block forms the new destination value and registers it. It does this according to the instruction form: a legacy form that leaves the upper bits alone, an unmasked form that clears everything past the vector length, and a masked form with merge or zero behaviour per lane.

Requests that cannot be encoded legally are rejected. A rejected request leaves the destination register as it was and raises a one-cycle flag. The floating-point addition itself and its exception flags belong to the lane adders outside this block.

Top module: `simd_lane_writeback`

## Requirements
- R1: `vlen_code` selects the active lane count: 00 gives 4 lanes, 01 gives 8 lanes, 10 gives 16 lanes, and 11 is reserved.
- R2: With `form_code` 00 (legacy), lanes 0 to 3 take their sums and lanes 4 to 15 take the `old_dst` value, whatever `vlen_code` holds.
- R3: With `form_code` 01 (unmasked), lanes below the active count take their sums and all other lanes become zero; `lane_mask` and `zeroing` have no effect.
- R4: With `form_code` 10 (masked), a lane below the active count whose `lane_mask` bit is 1 takes its sum.
- R5: In the masked form, a lane below the active count whose mask bit is 0 becomes zero when `zeroing` is 1, and takes its `old_dst` value when `zeroing` is 0.
- R6: In the masked form, lanes at or above the active count become zero regardless of their mask bits.
- R7: `addend` lane n equals element 0 of `src_b` when the masked form, the memory form (`reg_form`=0) and `bcast`=1 all hold. In every other case it equals element n, so `bcast` on the register form or on the other forms does not broadcast.
- R8: The `rc_out` codes are 00 round to nearest even, 01 toward minus infinity, 10 toward plus infinity and 11 toward zero. `rc_out` equals `emb_rc` when the request is in the masked form with `reg_form`=1, `bcast`=1 and `vlen_code`=10. Otherwise it equals `glob_rc`.
- R9: A legal request with `in_valid` high loads `dst` at that clock edge, and `out_valid` is high for exactly the following cycle. Without `in_valid`, `dst` holds its value.
- R10: A request is illegal when `form_code` is 11, when `vlen_code` is 11 in a non-legacy form, or when the legacy form has `bcast` or `zeroing` set. An illegal request leaves `dst` unchanged, keeps `out_valid` low, and drives `illegal` high for one cycle.
- R11: After reset, `dst` is zero and `out_valid` and `illegal` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request and sums are valid this cycle |
| form_code | input | 2 | 00 legacy, 01 unmasked, 10 masked, 11 reserved |
| vlen_code | input | 2 | Active lane count code |
| reg_form | input | 1 | Second source is a register (1) or memory (0) |
| bcast | input | 1 | Broadcast / rounding-override flag |
| zeroing | input | 1 | Zero masked-off lanes instead of merging |
| lane_mask | input | 16 | Per-lane write enable for the masked form |
| emb_rc | input | 2 | Rounding mode carried in the request |
| glob_rc | input | 2 | Global rounding mode |
| old_dst | input | 512 | Previous destination register value |
| src_b | input | 512 | Second source vector |
| lane_sum | input | 512 | Per-lane sums from the external adders |
| addend | output | 512 | Second operand routed to each lane adder |
| rc_out | output | 2 | Rounding mode for all lane adders |
| dst | output | 512 | Registered new destination value |
| out_valid | output | 1 | `dst` holds a new result this cycle |
| illegal | output | 1 | Previous request was rejected |

## Verification
The bench builds the block with its default of sixteen 32-bit lanes, so every vector-length code, including the reserved one, selects a real boundary. It also keeps the 4-lane legacy window distinct from the 8- and 16-lane lengths. At this width the lane count check at the 16-lane boundary is reachable. The rounding override at the widest length can be compared against the same request at 8 lanes. Masks of all zeros, all ones and mixed patterns drive both merge and zero paths across the boundary lanes.

// File: rtl/simd_lane_writeback.sv
`timescale 1ns/1ps
module simd_lane_writeback #(
  parameter int LANES        = 16,
  parameter int EW           = 32,
  parameter int LEGACY_LANES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [1:0]            form_code,
  input  logic [1:0]            vlen_code,
  input  logic                  reg_form,
  input  logic                  bcast,
  input  logic                  zeroing,
  input  logic [LANES-1:0]      lane_mask,
  input  logic [1:0]            emb_rc,
  input  logic [1:0]            glob_rc,
  input  logic [LANES*EW-1:0]   old_dst,
  input  logic [LANES*EW-1:0]   src_b,
  input  logic [LANES*EW-1:0]   lane_sum,
  output logic [LANES*EW-1:0]   addend,
  output logic [1:0]            rc_out,
  output logic [LANES*EW-1:0]   dst,
  output logic                  out_valid,
  output logic                  illegal
);
  localparam int VW = LANES * EW;
  localparam int LW = $clog2(LANES + 1);
  localparam logic [1:0] F_LEG = 2'b00, F_PLAIN = 2'b01, F_MASK = 2'b10;

  logic [LW-1:0] act_lanes;
  logic          bad_req;
  logic          bsel;
  logic [VW-1:0] next_dst;

  always_comb begin
    case (vlen_code)
      2'b00:   act_lanes = LW'(LANES / 4);
      2'b01:   act_lanes = LW'(LANES / 2);
      default: act_lanes = LW'(LANES);
    endcase
  end

  assign bad_req = (form_code == 2'b11)
                 || (form_code != F_LEG && vlen_code == 2'b11)
                 || (form_code == F_LEG && (bcast || zeroing));

  assign bsel   = (form_code == F_MASK) && !reg_form && bcast;
  assign rc_out = (form_code == F_MASK && reg_form && bcast && vlen_code == 2'b10)
                  ? emb_rc : glob_rc;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic          in_len;
    logic [EW-1:0] sum_i, old_i;
    assign in_len = LW'(i) < act_lanes;
    assign sum_i  = lane_sum[i*EW +: EW];
    assign old_i  = old_dst[i*EW +: EW];
    assign addend[i*EW +: EW] = bsel ? src_b[EW-1:0] : src_b[i*EW +: EW];

    always_comb begin
      case (form_code)
        F_LEG:   next_dst[i*EW +: EW] = (i < LEGACY_LANES) ? sum_i : old_i;
        F_PLAIN: next_dst[i*EW +: EW] = in_len ? sum_i : '0;
        default: begin
          if (!in_len)           next_dst[i*EW +: EW] = '0;
          else if (lane_mask[i]) next_dst[i*EW +: EW] = sum_i;
          else if (zeroing)      next_dst[i*EW +: EW] = '0;
          else                   next_dst[i*EW +: EW] = old_i;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst       <= '0;
      out_valid <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid && !bad_req;
      illegal   <= in_valid && bad_req;
      if (in_valid && !bad_req) dst <= next_dst;
    end
  end
endmodule

// File: rtl/simd_lane_writeback_chk.sv
`timescale 1ns/1ps
module simd_lane_writeback_chk #(
  parameter int LANES        = 16,
  parameter int EW           = 32,
  parameter int LEGACY_LANES = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [1:0]          form_code,
  input logic [1:0]          vlen_code,
  input logic                reg_form,
  input logic                bcast,
  input logic                zeroing,
  input logic [1:0]          glob_rc,
  input logic [LANES*EW-1:0] old_dst,
  input logic [LANES*EW-1:0] src_b,
  input logic [LANES*EW-1:0] addend,
  input logic [1:0]          rc_out,
  input logic [LANES*EW-1:0] dst,
  input logic                out_valid,
  input logic                illegal
);
  localparam int VW = LANES * EW;
  localparam int LB = LEGACY_LANES * EW;
  localparam int QB = (LANES / 4) * EW;

  p_legacy_keep_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && form_code == 2'b00 && !bcast && !zeroing
    |=> dst[VW-1:LB] == $past(old_dst[VW-1:LB]));

  p_short_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && form_code == 2'b10 && vlen_code == 2'b00
    |=> dst[VW-1:QB] == '0);

  p_bcast_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
    form_code == 2'b10 && !reg_form && bcast
    |-> addend[VW-1 -: EW] == src_b[EW-1:0]);

  p_rc_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(form_code == 2'b10 && reg_form) |-> rc_out == glob_rc);

  p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  p_ill_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $stable(dst));

  p_ill_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && illegal));
endmodule

bind simd_lane_writeback simd_lane_writeback_chk #(
  .LANES(LANES), .EW(EW), .LEGACY_LANES(LEGACY_LANES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .form_code(form_code),
  .vlen_code(vlen_code), .reg_form(reg_form), .bcast(bcast), .zeroing(zeroing),
  .glob_rc(glob_rc), .old_dst(old_dst), .src_b(src_b), .addend(addend),
  .rc_out(rc_out), .dst(dst), .out_valid(out_valid), .illegal(illegal)
);

// File: tb/simd_lane_writeback_tb.sv
`timescale 1ns/1ps
module simd_lane_writeback_tb;
  localparam int LANES = 16;
  localparam int EW    = 32;
  localparam int VW    = LANES * EW;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [1:0] form_code = 0, vlen_code = 0, emb_rc = 0, glob_rc = 0;
  logic reg_form = 0, bcast = 0, zeroing = 0;
  logic [LANES-1:0] lane_mask = 0;
  logic [VW-1:0] old_dst = 0, src_b = 0, lane_sum = 0;
  logic [VW-1:0] addend, dst;
  logic [1:0] rc_out;
  logic out_valid, illegal;

  int total = 0, bad = 0;
  bit done = 0;

  typedef struct packed { logic ill; logic [VW-1:0] d; } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];
  logic [VW-1:0] model_dst = '0;

  always #4 clk = ~clk;

  simd_lane_writeback u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .form_code(form_code),
    .vlen_code(vlen_code), .reg_form(reg_form), .bcast(bcast), .zeroing(zeroing),
    .lane_mask(lane_mask), .emb_rc(emb_rc), .glob_rc(glob_rc), .old_dst(old_dst),
    .src_b(src_b), .lane_sum(lane_sum), .addend(addend), .rc_out(rc_out),
    .dst(dst), .out_valid(out_valid), .illegal(illegal)
  );

  task automatic check(input bit ok, input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] rnd_vec();
    logic [VW-1:0] v;
    for (int i = 0; i < LANES; i++) v[i*EW +: EW] = $urandom;
    return v;
  endfunction

  function automatic logic [VW-1:0] exp_next(input logic [1:0] f, input logic [1:0] v,
      input logic [LANES-1:0] m, input logic z, input logic [VW-1:0] old, input logic [VW-1:0] sum);
    logic [VW-1:0] r;
    int n;
    n = (v == 2'b00) ? 4 : (v == 2'b01) ? 8 : 16;
    for (int i = 0; i < LANES; i++) begin
      if (f == 2'b00)      r[i*EW +: EW] = (i < 4) ? sum[i*EW +: EW] : old[i*EW +: EW];
      else if (f == 2'b01) r[i*EW +: EW] = (i < n) ? sum[i*EW +: EW] : '0;
      else if (i >= n)     r[i*EW +: EW] = '0;
      else if (m[i])       r[i*EW +: EW] = sum[i*EW +: EW];
      else if (z)          r[i*EW +: EW] = '0;
      else                 r[i*EW +: EW] = old[i*EW +: EW];
    end
    return r;
  endfunction

  task automatic send(input logic [1:0] f, input logic [1:0] v, input logic [LANES-1:0] m,
      input logic z, input logic b, input logic rf, input logic [1:0] erc, input logic [1:0] grc,
      input string tag);
    logic ill, bs;
    logic [VW-1:0] exp_add;
    logic [1:0] exp_rc;
    exp_t e;
    @(negedge clk);
    form_code = f; vlen_code = v; lane_mask = m; zeroing = z; bcast = b; reg_form = rf;
    emb_rc = erc; glob_rc = grc;
    old_dst = rnd_vec(); src_b = rnd_vec(); lane_sum = rnd_vec();
    in_valid = 1;
    ill = (f == 2'b11) || (f != 2'b00 && v == 2'b11) || (f == 2'b00 && (z || b));
    if (!ill) model_dst = exp_next(f, v, m, z, old_dst, lane_sum);
    e.ill = ill; e.d = model_dst;
    exp_q.push_back(e); tag_q.push_back(tag);
    bs = (f == 2'b10) && !rf && b;
    for (int i = 0; i < LANES; i++)
      exp_add[i*EW +: EW] = bs ? src_b[EW-1:0] : src_b[i*EW +: EW];
    exp_rc = (f == 2'b10 && rf && b && v == 2'b10) ? erc : grc;
    #1;
    check(addend == exp_add, {tag, " R7 addend"}, addend, exp_add);
    check(rc_out == exp_rc, {tag, " R8 rc"}, VW'(rc_out), VW'(exp_rc));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0;
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && (out_valid || illegal)) begin
      if (exp_q.size() == 0) begin
        check(0, "R9 unexpected output", {{(VW-2){1'b0}}, out_valid, illegal}, '0);
      end else begin
        exp_t e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        check(illegal == e.ill && out_valid == !e.ill, {t, " R9/R10 flags"},
              VW'({out_valid, illegal}), VW'({!e.ill, e.ill}));
        check(dst == e.d, {t, " dst"}, dst, e.d);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(0, "watchdog", '0, '1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(dst == '0 && !out_valid && !illegal, "R11 reset", dst, '0);
    @(negedge clk); rst_n = 1;

    send(2'b00, 2'b10, 16'h0000, 0, 0, 0, 2'b00, 2'b01, "R2 legacy vlen16");
    send(2'b00, 2'b11, 16'hFFFF, 0, 0, 1, 2'b11, 2'b10, "R2 R1 legacy reserved vlen");
    send(2'b01, 2'b00, 16'h0000, 1, 0, 0, 2'b00, 2'b11, "R3 R1 plain 4");
    send(2'b01, 2'b01, 16'h00F0, 0, 0, 0, 2'b00, 2'b00, "R3 R1 plain 8");
    send(2'b01, 2'b10, 16'h1234, 1, 1, 0, 2'b00, 2'b00, "R3 R7 plain 16 bcast ignored");
    idle(2);
    send(2'b10, 2'b10, 16'hFFFF, 0, 0, 0, 2'b00, 2'b00, "R4 masked all");
    send(2'b10, 2'b10, 16'hA5C3, 0, 0, 0, 2'b00, 2'b00, "R5 masked merge");
    send(2'b10, 2'b10, 16'hA5C3, 1, 0, 0, 2'b00, 2'b00, "R5 masked zero");
    send(2'b10, 2'b00, 16'hFFFF, 0, 0, 0, 2'b00, 2'b00, "R6 masked 4 full mask");
    send(2'b10, 2'b01, 16'hFF0F, 0, 0, 0, 2'b00, 2'b00, "R6 R5 masked 8 merge");
    send(2'b10, 2'b01, 16'h0000, 1, 0, 0, 2'b00, 2'b00, "R5 masked 8 none zero");
    send(2'b10, 2'b10, 16'h0F0F, 0, 1, 0, 2'b11, 2'b00, "R7 bcast memory");
    send(2'b10, 2'b10, 16'hFFFF, 0, 1, 1, 2'b11, 2'b00, "R8 R7 reg override 16");
    send(2'b10, 2'b01, 16'hFFFF, 0, 1, 1, 2'b11, 2'b10, "R8 reg no override 8");
    send(2'b10, 2'b10, 16'hFFFF, 0, 0, 1, 2'b10, 2'b01, "R8 reg no bcast");
    idle(1);
    send(2'b11, 2'b00, 16'hFFFF, 0, 0, 0, 2'b00, 2'b00, "R10 form reserved");
    send(2'b01, 2'b11, 16'hFFFF, 0, 0, 0, 2'b00, 2'b00, "R10 R1 vlen reserved");
    send(2'b00, 2'b00, 16'hFFFF, 1, 0, 0, 2'b00, 2'b00, "R10 legacy zeroing");
    send(2'b00, 2'b00, 16'hFFFF, 0, 1, 0, 2'b00, 2'b00, "R10 legacy bcast");
    send(2'b10, 2'b00, 16'h000A, 1, 0, 0, 2'b00, 2'b00, "R6 after illegal");
    idle(4);
    check(dst == model_dst && !out_valid && !illegal, "R9 hold when idle", dst, model_dst);
    check(exp_q.size() == 0, "R9 all results seen", VW'(exp_q.size()), '0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule